// File: doc/BRIEF.md
# Dual-Side Host Register Port with Burst Channel

This block is the slave end of an ISA-style parallel host connection that feeds two independent processor sides from one set of pins. The host drives a 3-bit register address, an active-low chip select, active-low read and write strobes and a 16-bit data bus. The top address bit picks the side. Within a side the host finds three registers: a byte-wide data register in the style of a MIDI UART, a status/control register, and a 16-bit burst port.

Each side passes bytes to its processor through a one-entry command holder and takes bytes back through a one-entry response holder. Burst words run through a small FIFO in each direction. Host strobes are brought into the core clock by two-flop synchronisers, and each access takes effect on the rising (trailing) edge of its strobe. For burst accesses only, the block drives an active-low 16-bit-transfer indicator. It also holds an active-low ready line low while the selected FIFO cannot take or give a word. That wait is bounded by a programmable cycle limit.

Top module: `host_reg_port`

## Requirements
- R1: The side is chosen by address bit 2 (codes 0 to 3 select side 0, codes 4 to 7 select side 1). Address bits 1:0 select the register: 00 is byte data, 01 is status/control, 10 is the burst port, and 11 reads as 0 and ignores writes.
- R2: A host write to 00 or 01 loads the low data byte into the side's command holder. The holder presents the byte on cmd_data with cmd_valid high, and cmd_ctrl is 1 for address 01 and 0 for address 00. The byte stays put until cmd_pop. A byte write while the holder is full is ignored.
- R3: A status read returns, in the low byte: bit 7 = 1 when no response byte is waiting, bit 6 = 1 when the command holder is full, and bits 5:4 = ext_flags. Bits 3:0 and the upper byte read 0. The reset value is 0x0080.
- R4: A read of 00 returns the response byte in bits 7:0 with the upper byte 0, and then empties the response holder, so that status bit 7 reads 1 again.
- R5: Burst writes enter a BURST_DEPTH-deep FIFO per side as full 16-bit words, and the core sees them in order on bw_data/bw_valid. A burst write to a full FIFO is dropped.
- R6: Core words pushed with br_push are returned by burst reads in order, all 16 bits valid. A read of an empty FIFO returns 0 and pops nothing.
- R7: hio16_n is low exactly while hcs_n is low and haddr[1:0] = 10, and high for byte and status accesses.
- R8: hready_n goes low only during a burst write to a full FIFO or a burst read from an empty FIFO. It returns high as soon as space or data appears, and stays high through accesses that find space or data.
- R9: hready_n is never held low for more than WAIT_LIMIT consecutive cycles. After that limit the access completes: a write is dropped, and a read of an empty FIFO returns 0.
- R10: hdata_oe is 1 only while hcs_n and hrd_n are both low.
- R11: An access to one side leaves the other side's registers and FIFOs unchanged.
- R12: After reset hready_n = 1, hio16_n = 1, hdata_oe = 0, cmd_valid = 0 and bw_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hcs_n | input | 1 | Host chip select, active low |
| hrd_n | input | 1 | Host read strobe, active low |
| hwr_n | input | 1 | Host write strobe, active low |
| haddr | input | 3 | Host register address |
| hdata_in | input | 16 | Host write data |
| hdata_out | output | 16 | Host read data |
| hdata_oe | output | 1 | Enable for the external data-bus driver |
| hready_n | output | 1 | Wait request to host, active low |
| hio16_n | output | 1 | 16-bit transfer indicator, active low |
| cmd_valid | output | 2 | Command byte waiting, per side |
| cmd_data | output | 2x8 | Command byte, per side |
| cmd_ctrl | output | 2 | Command came from the status/control address |
| cmd_pop | input | 2 | Core takes the command byte |
| rsp_push | input | 2 | Core offers a response byte |
| rsp_data | input | 2x8 | Response byte, per side |
| rsp_full | output | 2 | Response holder occupied |
| ext_flags | input | 2x2 | Extension status bits, per side |
| bw_valid | output | 2 | Burst write word available to core |
| bw_data | output | 2x16 | Head of burst write FIFO |
| bw_pop | input | 2 | Core takes a burst write word |
| br_push | input | 2 | Core pushes a burst read word |
| br_data | input | 2x16 | Burst read word from core |
| br_full | output | 2 | Burst read FIFO full |

## Verification
The bench builds the block with BURST_DEPTH = 4 and WAIT_LIMIT = 16. This makes an overfilled write FIFO and a starved read FIFO reach the wait limit within a few tens of cycles. The bench can therefore count the exact length of the ready-low window and check both the dropped fifth write and the zero returned by a timed-out read. It also releases a stalled read midway by pushing a core word, which exercises early release of ready.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int NSIDE = 2;

  typedef enum logic [1:0] {
    REG_DATA  = 2'b00,
    REG_STAT  = 2'b01,
    REG_BURST = 2'b10,
    REG_NONE  = 2'b11
  } reg_sel_e;

  function automatic logic side_of(input logic [2:0] a);
    return a[2];
  endfunction

  function automatic reg_sel_e reg_of(input logic [2:0] a);
    return reg_sel_e'(a[1:0]);
  endfunction

  function automatic logic [7:0] status_byte(input logic have_rsp,
                                              input logic cmd_full,
                                              input logic [1:0] ext);
    return {~have_rsp, cmd_full, ext, 4'b0000};
  endfunction
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/hp_fifo.sv
module hp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;
  logic         do_push, do_pop;

  assign full    = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign empty   = (wptr == rptr);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr[AW-1:0]] <= din;
  end

  AST_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> $stable(wptr)); // R5
  AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> $stable(rptr)); // R6
endmodule

// File: rtl/hp_side.sv
module hp_side import hp_pkg::*; #(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_wr_byte,
  input  logic        h_wr_ctrl,
  input  logic        h_wr_burst,
  input  logic        h_rd_byte,
  input  logic        h_rd_burst,
  input  logic [15:0] h_wdata,
  output logic [7:0]  h_rsp_byte,
  output logic [7:0]  h_status,
  output logic [15:0] h_burst_head,
  output logic        h_wfull,
  output logic        h_rempty,
  output logic        cmd_valid,
  output logic [7:0]  cmd_data,
  output logic        cmd_ctrl,
  input  logic        cmd_pop,
  input  logic        rsp_push,
  input  logic [7:0]  rsp_data,
  output logic        rsp_full,
  input  logic [1:0]  ext_flags,
  output logic        bw_valid,
  output logic [15:0] bw_data,
  input  logic        bw_pop,
  input  logic        br_push,
  input  logic [15:0] br_data,
  output logic        br_full
);
  logic        rsp_have;
  logic        bw_empty;
  logic [15:0] br_head;
  logic        host_byte_wr;

  assign host_byte_wr = h_wr_byte || h_wr_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
      cmd_ctrl  <= 1'b0;
    end else if (host_byte_wr && !cmd_valid) begin
      cmd_valid <= 1'b1;
      cmd_data  <= h_wdata[7:0];
      cmd_ctrl  <= h_wr_ctrl;
    end else if (cmd_pop) begin
      cmd_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_have   <= 1'b0;
      h_rsp_byte <= '0;
    end else if (rsp_push && !rsp_have) begin
      rsp_have   <= 1'b1;
      h_rsp_byte <= rsp_data;
    end else if (h_rd_byte) begin
      rsp_have   <= 1'b0;
    end
  end

  assign rsp_full     = rsp_have;
  assign h_status     = status_byte(rsp_have, cmd_valid, ext_flags);
  assign bw_valid     = !bw_empty;
  assign h_burst_head = h_rempty ? 16'h0000 : br_head;

  hp_fifo #(.W(16), .DEPTH(DEPTH)) u_wr_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(h_wr_burst), .din(h_wdata),
    .pop(bw_pop), .dout(bw_data),
    .full(h_wfull), .empty(bw_empty)
  );

  hp_fifo #(.W(16), .DEPTH(DEPTH)) u_rd_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(br_push), .din(br_data),
    .pop(h_rd_burst), .dout(br_head),
    .full(br_full), .empty(h_rempty)
  );

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_pop) |=> (cmd_valid && $stable(cmd_data) && $stable(cmd_ctrl))); // R2
endmodule

// File: rtl/host_reg_port.sv
module host_reg_port import hp_pkg::*; #(
  parameter int BURST_DEPTH = 4,
  parameter int WAIT_LIMIT  = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hcs_n,
  input  logic                   hrd_n,
  input  logic                   hwr_n,
  input  logic [2:0]             haddr,
  input  logic [15:0]            hdata_in,
  output logic [15:0]            hdata_out,
  output logic                   hdata_oe,
  output logic                   hready_n,
  output logic                   hio16_n,
  output logic [NSIDE-1:0]       cmd_valid,
  output logic [NSIDE-1:0][7:0]  cmd_data,
  output logic [NSIDE-1:0]       cmd_ctrl,
  input  logic [NSIDE-1:0]       cmd_pop,
  input  logic [NSIDE-1:0]       rsp_push,
  input  logic [NSIDE-1:0][7:0]  rsp_data,
  output logic [NSIDE-1:0]       rsp_full,
  input  logic [NSIDE-1:0][1:0]  ext_flags,
  output logic [NSIDE-1:0]       bw_valid,
  output logic [NSIDE-1:0][15:0] bw_data,
  input  logic [NSIDE-1:0]       bw_pop,
  input  logic [NSIDE-1:0]       br_push,
  input  logic [NSIDE-1:0][15:0] br_data,
  output logic [NSIDE-1:0]       br_full
);
  localparam int CW = $clog2(WAIT_LIMIT + 1);

  // synchronised strobes: [2]=cs, [1]=rd, [0]=wr (all active low)
  logic [2:0]  strb_s, strb_p, addr_s;
  logic [15:0] wdata_q;
  logic        cs_act, rd_low, wr_low, rd_end, wr_end;
  logic        side_s, side_r;
  reg_sel_e    reg_s, reg_r;

  hp_sync #(.W(3), .RST_VAL(3'b111)) u_strobe_sync (
    .clk(clk), .rst_n(rst_n), .d({hcs_n, hrd_n, hwr_n}), .q(strb_s));
  hp_sync #(.W(3), .RST_VAL(3'b000)) u_addr_sync (
    .clk(clk), .rst_n(rst_n), .d(haddr), .q(addr_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_p  <= 3'b111;
      wdata_q <= '0;
    end else begin
      strb_p <= strb_s;
      if (!strb_s[0]) wdata_q <= hdata_in;
    end
  end

  assign cs_act = !strb_s[2];
  assign rd_low = !strb_s[1];
  assign wr_low = !strb_s[0];
  assign rd_end = !strb_p[1] && strb_s[1] && !strb_p[2];
  assign wr_end = !strb_p[0] && strb_s[0] && !strb_p[2];
  assign side_s = side_of(addr_s);
  assign reg_s  = reg_of(addr_s);
  assign side_r = side_of(haddr);
  assign reg_r  = reg_of(haddr);

  logic [NSIDE-1:0][7:0]  rsp_b, stat_b;
  logic [NSIDE-1:0][15:0] head_w;
  logic [NSIDE-1:0]       wfull, rempty;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    logic sel;
    assign sel = (side_s == 1'(g));
    hp_side #(.DEPTH(BURST_DEPTH)) u_side (
      .clk(clk), .rst_n(rst_n),
      .h_wr_byte (wr_end && sel && reg_s == REG_DATA),
      .h_wr_ctrl (wr_end && sel && reg_s == REG_STAT),
      .h_wr_burst(wr_end && sel && reg_s == REG_BURST),
      .h_rd_byte (rd_end && sel && reg_s == REG_DATA),
      .h_rd_burst(rd_end && sel && reg_s == REG_BURST),
      .h_wdata(wdata_q),
      .h_rsp_byte(rsp_b[g]), .h_status(stat_b[g]), .h_burst_head(head_w[g]),
      .h_wfull(wfull[g]), .h_rempty(rempty[g]),
      .cmd_valid(cmd_valid[g]), .cmd_data(cmd_data[g]), .cmd_ctrl(cmd_ctrl[g]),
      .cmd_pop(cmd_pop[g]),
      .rsp_push(rsp_push[g]), .rsp_data(rsp_data[g]), .rsp_full(rsp_full[g]),
      .ext_flags(ext_flags[g]),
      .bw_valid(bw_valid[g]), .bw_data(bw_data[g]), .bw_pop(bw_pop[g]),
      .br_push(br_push[g]), .br_data(br_data[g]), .br_full(br_full[g])
    );
  end

  always_comb begin
    case (reg_r)
      REG_DATA:  hdata_out = {8'h00, rsp_b[side_r]};
      REG_STAT:  hdata_out = {8'h00, stat_b[side_r]};
      REG_BURST: hdata_out = head_w[side_r];
      default:   hdata_out = 16'h0000;
    endcase
  end

  assign hdata_oe = !hcs_n && !hrd_n;
  assign hio16_n  = !(!hcs_n && reg_r == REG_BURST);

  // wait handshake with bounded hold time
  logic          stall, expired;
  logic [CW-1:0] wait_cnt;

  assign stall = cs_act && (reg_s == REG_BURST) &&
                 ((wr_low && wfull[side_s]) || (rd_low && rempty[side_s]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      expired  <= 1'b0;
    end else if (!stall) begin
      wait_cnt <= '0;
      expired  <= 1'b0;
    end else if (!expired) begin
      if (wait_cnt == CW'(WAIT_LIMIT - 1)) expired  <= 1'b1;
      else                                 wait_cnt <= wait_cnt + 1'b1;
    end
  end

  assign hready_n = !(stall && !expired);

  // independent run-length counter for the wait bound
  logic [CW:0] chk_low;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         chk_low <= '0;
    else if (!hready_n) chk_low <= chk_low + 1'b1;
    else                chk_low <= '0;
  end

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(chk_low) <= WAIT_LIMIT)); // R9
  AST_READY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !hready_n |-> (wfull[side_s] || rempty[side_s])); // R8
endmodule

// File: tb/host_reg_port_test.sv
module host_reg_port_test;
  localparam int NS = 2;
  localparam int WL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hcs_n = 1'b1, hrd_n = 1'b1, hwr_n = 1'b1;
  logic [2:0]  haddr = 3'd0;
  logic [15:0] hdata_in = 16'h0000;
  logic [15:0] hdata_out;
  logic hdata_oe, hready_n, hio16_n;
  logic [NS-1:0]       cmd_valid, cmd_ctrl, rsp_full, bw_valid, br_full;
  logic [NS-1:0][7:0]  cmd_data;
  logic [NS-1:0][15:0] bw_data;
  logic [NS-1:0]       cmd_pop = '0, rsp_push = '0, bw_pop = '0, br_push = '0;
  logic [NS-1:0][7:0]  rsp_data = '0;
  logic [NS-1:0][1:0]  ext_flags = '0;
  logic [NS-1:0][15:0] br_data = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic oe_seen, io16_seen;

  always #10 clk = ~clk;

  host_reg_port #(.BURST_DEPTH(4), .WAIT_LIMIT(WL)) uut (
    .clk(clk), .rst_n(rst_n), .hcs_n(hcs_n), .hrd_n(hrd_n), .hwr_n(hwr_n),
    .haddr(haddr), .hdata_in(hdata_in), .hdata_out(hdata_out),
    .hdata_oe(hdata_oe), .hready_n(hready_n), .hio16_n(hio16_n),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ctrl(cmd_ctrl), .cmd_pop(cmd_pop),
    .rsp_push(rsp_push), .rsp_data(rsp_data), .rsp_full(rsp_full), .ext_flags(ext_flags),
    .bw_valid(bw_valid), .bw_data(bw_data), .bw_pop(bw_pop),
    .br_push(br_push), .br_data(br_data), .br_full(br_full)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic host_read(input logic [2:0] a, output logic [15:0] d, output int lowcnt);
    @(negedge clk); haddr = a; hcs_n = 1'b0;
    @(negedge clk); hrd_n = 1'b0; lowcnt = 0;
    repeat (4) begin @(negedge clk); if (!hready_n) lowcnt++; end
    while (!hready_n && lowcnt < 1000) begin @(negedge clk); if (!hready_n) lowcnt++; end
    d = hdata_out; oe_seen = hdata_oe; io16_seen = hio16_n;
    hrd_n = 1'b1;
    @(negedge clk); hcs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic host_write(input logic [2:0] a, input logic [15:0] d, output int lowcnt);
    @(negedge clk); haddr = a; hdata_in = d; hcs_n = 1'b0;
    @(negedge clk); hwr_n = 1'b0; lowcnt = 0;
    repeat (4) begin @(negedge clk); if (!hready_n) lowcnt++; end
    while (!hready_n && lowcnt < 1000) begin @(negedge clk); if (!hready_n) lowcnt++; end
    io16_seen = hio16_n;
    hwr_n = 1'b1;
    @(negedge clk); hcs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // {is_write, addr[2:0], data[15:0], expected read[15:0]}
  localparam logic [35:0] VEC [9] = '{
    {1'b0, 3'd1, 16'h0000, 16'h0080},
    {1'b1, 3'd0, 16'h7741, 16'h0000},
    {1'b0, 3'd1, 16'h0000, 16'h00C0},
    {1'b1, 3'd5, 16'h00FF, 16'h0000},
    {1'b0, 3'd5, 16'h0000, 16'h00C0},
    {1'b1, 3'd2, 16'h1234, 16'h0000},
    {1'b1, 3'd2, 16'hABCD, 16'h0000},
    {1'b1, 3'd6, 16'h5555, 16'h0000},
    {1'b0, 3'd4, 16'h0000, 16'h0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int lc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    check("R12 ready", hready_n, 1);
    check("R12 io16", hio16_n, 1);
    check("R12 oe", hdata_oe, 0);
    check("R12 cmd_valid", cmd_valid, 0);
    check("R12 bw_valid", bw_valid, 0);

    for (int i = 0; i < 9; i++) begin
      if (VEC[i][35]) begin
        host_write(VEC[i][34:32], VEC[i][31:16], lc);
        check($sformatf("R8 vec%0d no wait", i), lc, 0);
      end else begin
        host_read(VEC[i][34:32], d, lc);
        check($sformatf("R1 R3 vec%0d read", i), d, VEC[i][15:0]);
        check($sformatf("R7 vec%0d io16 high", i), io16_seen, 1);
      end
    end

    // R2: command bytes per side
    check("R2 side0 data", cmd_data[0], 8'h41);
    check("R2 side0 ctrl", cmd_ctrl[0], 0);
    check("R2 side1 data", cmd_data[1], 8'hFF);
    check("R2 side1 ctrl", cmd_ctrl[1], 1);
    host_write(3'd0, 16'h0099, lc);
    check("R2 full write ignored", cmd_data[0], 8'h41);
    @(negedge clk); cmd_pop = 2'b11; @(negedge clk); cmd_pop = 2'b00;
    check("R2 popped", cmd_valid, 0);
    host_read(3'd1, d, lc);
    check("R3 status after pop", d, 16'h0080);

    // R4: response byte on side 1
    @(negedge clk); ext_flags[1] = 2'b01; rsp_data[1] = 8'h3C; rsp_push[1] = 1'b1;
    @(negedge clk); rsp_push[1] = 1'b0;
    host_read(3'd5, d, lc);
    check("R3 status ext+data", d, 16'h0010);
    host_read(3'd4, d, lc);
    check("R4 byte read", d, 16'h003C);
    host_read(3'd5, d, lc);
    check("R4 status after read", d, 16'h0090);
    host_read(3'd1, d, lc);
    check("R11 side0 status untouched", d, 16'h0080);

    // R5: write FIFO order and side separation
    check("R5 side0 head1", bw_data[0], 16'h1234);
    @(negedge clk); bw_pop[0] = 1'b1; @(negedge clk); bw_pop[0] = 1'b0;
    check("R5 side0 head2", bw_data[0], 16'hABCD);
    @(negedge clk); bw_pop[0] = 1'b1; @(negedge clk); bw_pop[0] = 1'b0;
    check("R5 side0 drained", bw_valid[0], 0);
    check("R11 side1 burst kept", bw_data[1], 16'h5555);

    // R5/R9: overfill side 0
    for (int k = 0; k < 4; k++) begin
      host_write(3'd2, 16'h1001 + 16'(k), lc);
      check("R8 space no wait", lc, 0);
    end
    host_write(3'd2, 16'h1005, lc);
    check("R9 full write wait length", lc, WL);
    check("R7 io16 burst write", io16_seen, 0);
    for (int k = 0; k < 4; k++) begin
      check("R5 fifo order", bw_data[0], 16'h1001 + 16'(k));
      @(negedge clk); bw_pop[0] = 1'b1; @(negedge clk); bw_pop[0] = 1'b0;
    end
    check("R5 fifth dropped", bw_valid[0], 0);

    // R8: read stalls on empty, released by core push
    fork
      host_read(3'd2, d, lc);
      begin
        repeat (8) @(negedge clk);
        check("R8 ready low on empty", hready_n, 0);
        br_data[0] = 16'hBEEF; br_push[0] = 1'b1;
        @(negedge clk); br_push[0] = 1'b0;
      end
    join
    check("R6 released read data", d, 16'hBEEF);
    check("R8 early release", (lc > 0 && lc < WL), 1);

    @(negedge clk); br_data[0] = 16'hC0DE; br_push[0] = 1'b1;
    @(negedge clk); br_data[0] = 16'hF00D;
    @(negedge clk); br_push[0] = 1'b0;
    host_read(3'd2, d, lc);
    check("R6 order 1", d, 16'hC0DE);
    check("R8 data ready no wait", lc, 0);
    check("R7 io16 burst read", io16_seen, 0);
    check("R10 oe during read", oe_seen, 1);
    host_read(3'd2, d, lc);
    check("R6 order 2", d, 16'hF00D);

    // R9: timed-out read of empty FIFO
    host_read(3'd2, d, lc);
    check("R9 empty read value", d, 16'h0000);
    check("R9 empty read wait length", lc, WL);

    check("R10 oe idle", hdata_oe, 0);
    check("R7 io16 idle", hio16_n, 1);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule